// File: doc/BRIEF.md
# Multiplexed Bus Target Address Latch

This block sits on the far side of a shared address/data bus whose transfers open with a single address cycle and continue with one or more data cycles. In the cycle where the start strobe and chip-select are both high, it latches the transfer address, the access-size code and the direction. The bus does not drive any of these again. For each data cycle that follows, the block produces one beat address and a read or write strobe on a simple internal memory port.

Block transfers walk through the aligned 32-byte block, starting at the requested word and wrapping. Paired transfers toggle between the two words of an aligned 8-byte pair. Single transfers use the latched address. The frame signal falls for the final data cycle, and the block flags any transfer whose frame timing does not match the beat count implied by the size code.

On reads, the word returned by the memory port is driven onto the bus, but only in data cycles. On writes, the bus word is passed to the memory port with one write strobe per beat. Chip-select may remain high, and a new start strobe may arrive in the cycle right after the last beat.

Top module: `mpx_target`

## Requirements
- R1: While rst_ni is low, and in idle cycles after it, mem_rd_o, mem_wr_o, ad_oe_o and err_o are 0.
- R2: The address phase is a cycle with bs_i=1 and cs_i=1. In that cycle the block latches ad_i[25:0] as the address, ad_i[31:29] as the size code and rd_i (1 = read, 0 = write). Bus values in later cycles do not change the beat addresses.
- R3: Size codes 000, 001 and 010 give exactly one data beat, at the latched address.
- R4: Size code 011 gives two beats. The second beat is the latched address with bit 2 inverted.
- R5: Size codes 1xx give eight beats. Beat k has bits 4..2 equal to (latched bits 4..2 + k) mod 8, and all other bits equal to the latched ones.
- R6: A data cycle is a cycle after the address phase with cs_i=1 and bs_i=0. On a read, each data cycle gives mem_rd_o=1, ad_oe_o=1 and ad_o=mem_rdata_i. ad_oe_o is 0 in every other cycle, including address phases.
- R7: On a write, each data cycle gives mem_wr_o=1 and mem_wdata_o=ad_i. mem_rd_o and mem_wr_o are never both high.
- R8: A data cycle with frame_i=0 is the last beat. No further strobe occurs until a new address phase.
- R9: An address phase in the cycle right after a last beat starts a new transfer, with no idle cycle in between.
- R10: err_o is high for one cycle right after a data cycle whose frame_i is wrong: 0 before the expected last beat, or still 1 on or after it. The expected beat count is 1, 1, 1, 2 or 8 from the size code.
- R11: When cs_i falls during a transfer, the transfer ends. Later data-like cycles produce no strobe until a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bs_i | input | 1 | Start strobe marking the address phase |
| cs_i | input | 1 | Chip-select for this target |
| frame_i | input | 1 | High while more data beats follow |
| rd_i | input | 1 | Direction in the address phase, 1 = read |
| ad_i | input | 32 | Multiplexed address/data bus, incoming |
| ad_o | output | 32 | Read data driven toward the bus |
| ad_oe_o | output | 1 | Bus drive enable for ad_o |
| mem_addr_o | output | 26 | Beat address to the memory port |
| mem_rd_o | output | 1 | Memory read strobe, one per read beat |
| mem_wr_o | output | 1 | Memory write strobe, one per write beat |
| mem_wdata_o | output | 32 | Write data to the memory port |
| mem_rdata_i | input | 32 | Combinational read data from the memory port |
| err_o | output | 1 | One-cycle frame protocol error pulse |

## Verification
The bench targets block transfers that start mid-block, at word 7 and at word 0. A design that carries into bit 5 instead of wrapping would fetch from the next block. Paired transfers that start on an odd word expose a design that adds instead of toggling bit 2. Back-to-back transfers with chip-select held high catch a design that needs an idle cycle, or that reads the new address phase as a data beat. Read data cycles in which the bus carries garbage would reveal an address that is not held. Frame that falls early or stays high late, and chip-select that drops mid-transfer, check that err_o fires exactly on the offending beats and that an aborted transfer leaves no stray strobe.

// File: rtl/mpx_tgt_pkg.sv
package mpx_tgt_pkg;

  typedef enum logic [1:0] {
    SZ_SINGLE = 2'd0,
    SZ_PAIR   = 2'd1,
    SZ_BLOCK  = 2'd2
  } sz_class_e;

  function automatic sz_class_e classify(input logic [2:0] code);
    if (code[2])             return SZ_BLOCK;
    else if (code[1:0] == 2'b11) return SZ_PAIR;
    else                     return SZ_SINGLE;
  endfunction

endpackage

// File: rtl/mpx_size_dec.sv
module mpx_size_dec
  import mpx_tgt_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int CNT_W = 4
) (
  input  logic [2:0]       code_i,
  output logic [CNT_W-1:0] last_o,  // index of final beat
  output logic [IDX_W-1:0] mask_o   // word-index bits that advance per beat
);

  localparam logic [CNT_W-1:0] BLK_LAST = CNT_W'((1 << IDX_W) - 1);

  always_comb begin
    unique case (classify(code_i))
      SZ_BLOCK: begin last_o = BLK_LAST;      mask_o = '1;           end
      SZ_PAIR:  begin last_o = CNT_W'(1);     mask_o = IDX_W'(1);    end
      default:  begin last_o = '0;            mask_o = '0;           end
    endcase
  end

endmodule

// File: rtl/mpx_beat_addr.sv
module mpx_beat_addr #(
  parameter int ADDR_W   = 26,
  parameter int WORD_LSB = 2,
  parameter int IDX_W    = 3
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IDX_W-1:0]  mask_i,
  input  logic [IDX_W-1:0]  step_i,
  output logic [ADDR_W-1:0] addr_o
);

  logic [IDX_W-1:0] word, inc, sel;

  always_comb begin
    word = base_i[WORD_LSB +: IDX_W];
    inc  = word + step_i;                     // wraps mod 2**IDX_W
    sel  = (inc & mask_i) | (word & ~mask_i);
    addr_o = base_i;
    addr_o[WORD_LSB +: IDX_W] = sel;
  end

endmodule

// File: rtl/mpx_seq.sv
module mpx_seq #(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bs_i,
  input  logic              cs_i,
  input  logic              frame_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] ad_i,
  input  logic [CNT_W-1:0]  last_i,
  output logic              beat_o,
  output logic              rd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [2:0]        size_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              err_o
);

  localparam int SIZE_LSB = DATA_W - 3;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic              act_q, rd_q, err_q;
  logic [ADDR_W-1:0] addr_q;
  logic [2:0]        size_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              start, beat, bad;

  assign start = bs_i & cs_i;
  assign beat  = act_q & cs_i & ~bs_i;
  assign bad   = beat & ((~frame_i & (cnt_q != last_i)) |
                         ( frame_i & (cnt_q >= last_i)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      rd_q   <= 1'b0;
      addr_q <= '0;
      size_q <= '0;
      cnt_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= bad;
      if (start) begin
        act_q  <= 1'b1;
        cnt_q  <= '0;
        addr_q <= ad_i[ADDR_W-1:0];
        size_q <= ad_i[SIZE_LSB +: 3];
        rd_q   <= rd_i;
      end else if (beat && !frame_i) begin
        act_q <= 1'b0;
      end else if (beat) begin
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end else if (!cs_i) begin
        act_q <= 1'b0;
      end
    end
  end

  assign beat_o = beat;
  assign rd_o   = rd_q;
  assign addr_o = addr_q;
  assign size_o = size_q;
  assign cnt_o  = cnt_q;
  assign err_o  = err_q;

  AST_CNT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (cnt_q == '0 && act_q)) else $error("count not restarted"); // R9

endmodule

// File: rtl/mpx_target.sv
module mpx_target #(
  parameter int ADDR_W      = 26,
  parameter int DATA_W      = 32,
  parameter int BLOCK_BYTES = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bs_i,
  input  logic              cs_i,
  input  logic              frame_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              err_o
);

  localparam int WORD_LSB = $clog2(DATA_W / 8);
  localparam int IDX_W    = $clog2(BLOCK_BYTES) - WORD_LSB;
  localparam int CNT_W    = IDX_W + 1;
  localparam int BLK_LSB  = WORD_LSB + IDX_W;

  logic              beat, rd_q;
  logic [ADDR_W-1:0] base;
  logic [2:0]        size;
  logic [CNT_W-1:0]  cnt, last;
  logic [IDX_W-1:0]  mask;

  mpx_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bs_i    (bs_i),
    .cs_i    (cs_i),
    .frame_i (frame_i),
    .rd_i    (rd_i),
    .ad_i    (ad_i),
    .last_i  (last),
    .beat_o  (beat),
    .rd_o    (rd_q),
    .addr_o  (base),
    .size_o  (size),
    .cnt_o   (cnt),
    .err_o   (err_o)
  );

  mpx_size_dec #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_dec (
    .code_i (size),
    .last_o (last),
    .mask_o (mask)
  );

  mpx_beat_addr #(.ADDR_W(ADDR_W), .WORD_LSB(WORD_LSB), .IDX_W(IDX_W)) u_addr (
    .base_i (base),
    .mask_i (mask),
    .step_i (cnt[IDX_W-1:0]),
    .addr_o (mem_addr_o)
  );

  assign mem_rd_o    = beat & rd_q;
  assign mem_wr_o    = beat & ~rd_q;
  assign mem_wdata_o = ad_i;
  assign ad_oe_o     = mem_rd_o;
  assign ad_o        = mem_rdata_i;

  AST_NO_DRIVE_ADDR_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bs_i |-> !ad_oe_o) else $error("bus driven in address phase"); // R6

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o)) else $error("both strobes"); // R7

  AST_BLOCK_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mem_rd_o || mem_wr_o) && frame_i && size[2]) |=>
      (!(mem_rd_o || mem_wr_o) ||
       (mem_addr_o[WORD_LSB +: IDX_W] == $past(mem_addr_o[WORD_LSB +: IDX_W]) + 1'b1 &&
        mem_addr_o[ADDR_W-1:BLK_LSB] == $past(mem_addr_o[ADDR_W-1:BLK_LSB]))))
    else $error("block beat did not wrap-step"); // R5

  AST_QUIET_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mem_rd_o || mem_wr_o) && !frame_i) |=> !(mem_rd_o || mem_wr_o))
    else $error("strobe after last beat"); // R8

  AST_ERR_AFTER_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(mem_rd_o || mem_wr_o)) else $error("error without beat"); // R10

endmodule

// File: tb/mpx_target_tb.sv
module mpx_target_tb;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bs_i = 1'b0, cs_i = 1'b0, frame_i = 1'b0, rd_i = 1'b0;
  logic [31:0] ad_i = '0;
  logic [31:0] ad_o, mem_wdata_o, mem_rdata_i;
  logic [25:0] mem_addr_o;
  logic        ad_oe_o, mem_rd_o, mem_wr_o, err_o;

  int checks = 0, failures = 0;

  // reference model state
  bit          m_act = 0, m_rd = 0, m_err = 0;
  int          m_n = 0;
  logic [25:0] m_addr = '0;
  logic [2:0]  m_size = '0;

  always #10 clk = ~clk;  // 50 MHz

  assign mem_rdata_i = {mem_addr_o, 6'h2B} ^ 32'h5A5A_0000;

  mpx_target u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .bs_i(bs_i), .cs_i(cs_i), .frame_i(frame_i),
    .rd_i(rd_i), .ad_i(ad_i), .ad_o(ad_o), .ad_oe_o(ad_oe_o),
    .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int n_beats(input logic [2:0] s);
    if (s[2]) return 8;
    if (s == 3'b011) return 2;
    return 1;
  endfunction

  function automatic logic [25:0] exp_addr(input logic [25:0] b, input logic [2:0] s, input int n);
    logic [25:0] a;
    a = b;
    if (s[2]) a[4:2] = 3'((int'(b[4:2]) + n) % 8);
    else if (s == 3'b011) a[2] = b[2] ^ n[0];
    return a;
  endfunction

  // one bus cycle: drive, compare against model, then advance model
  task automatic cyc(input bit bs, input bit cs, input bit fr, input bit rd, input logic [31:0] ad);
    bit beat, bad;
    int last;
    @(negedge clk);
    bs_i = bs; cs_i = cs; frame_i = fr; rd_i = rd; ad_i = ad;
    #3;
    beat = m_act && cs && !bs;
    last = n_beats(m_size) - 1;
    chk(mem_rd_o == (beat && m_rd), "R6 mem_rd_o", 32'(mem_rd_o), 32'(beat && m_rd));
    chk(mem_wr_o == (beat && !m_rd), "R7 mem_wr_o", 32'(mem_wr_o), 32'(beat && !m_rd));
    chk(ad_oe_o == (beat && m_rd), "R6 ad_oe_o", 32'(ad_oe_o), 32'(beat && m_rd));
    chk(err_o == m_err, "R10 err_o", 32'(err_o), 32'(m_err));
    if (beat) begin
      chk(mem_addr_o == exp_addr(m_addr, m_size, m_n), "R5 mem_addr_o",
          32'(mem_addr_o), 32'(exp_addr(m_addr, m_size, m_n)));
      if (m_rd) chk(ad_o == ({exp_addr(m_addr, m_size, m_n), 6'h2B} ^ 32'h5A5A_0000),
                    "R6 ad_o", ad_o, {exp_addr(m_addr, m_size, m_n), 6'h2B} ^ 32'h5A5A_0000);
      else chk(mem_wdata_o == ad, "R7 mem_wdata_o", mem_wdata_o, ad);
    end
    bad = beat && ((!fr && m_n != last) || (fr && m_n >= last));
    m_err = bad;
    if (bs && cs) begin
      m_act = 1; m_n = 0; m_addr = ad[25:0]; m_size = ad[31:29]; m_rd = rd;
    end else if (beat && !fr) m_act = 0;
    else if (beat) m_n++;
    else if (!cs) m_act = 0;
  endtask

  // address phase plus nb data beats; frame low on the last driven beat
  task automatic txn(input bit rd, input logic [2:0] sz, input logic [25:0] a, input int nb, input bit gap);
    cyc(1, 1, 1, rd, {sz, 3'b000, a});
    for (int k = 0; k < nb; k++)
      cyc(0, 1, (k != nb - 1), rd, 32'hC0DE_0000 + 32'(k * 32'h1111));
    if (gap) cyc(0, 0, 0, 0, 32'hFFFF_FFFF);
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset holds everything quiet even with strobes toggling
    bs_i = 1; cs_i = 1; frame_i = 1; rd_i = 1;
    repeat (3) @(negedge clk);
    #3;
    chk(!mem_rd_o && !mem_wr_o && !ad_oe_o && !err_o, "R1 reset outputs",
        {28'd0, mem_rd_o, mem_wr_o, ad_oe_o, err_o}, 32'd0);
    @(negedge clk); rst_ni = 1; bs_i = 0; cs_i = 0;
    cyc(0, 0, 0, 0, '0);
    cyc(0, 1, 1, 1, '0);  // R1: data-like cycle without address phase is idle

    // R3, R6: single-beat reads of each small size
    txn(1, 3'b000, 26'h000_0013, 1, 1);
    txn(1, 3'b001, 26'h123_4566, 1, 1);
    txn(1, 3'b010, 26'h3FF_FFFC, 1, 1);
    // R7: single write
    txn(0, 3'b010, 26'h010_0008, 1, 1);
    // R4: pair starting on odd and even word
    txn(1, 3'b011, 26'h020_0004, 2, 1);
    txn(0, 3'b011, 26'h020_0010, 2, 1);
    // R5, R2: block reads mid-block, at word 7, writes at word 0
    txn(1, 3'b100, 26'h0AB_CD14, 8, 1);
    txn(1, 3'b111, 26'h3FF_FFFC, 8, 1);
    txn(0, 3'b101, 26'h155_5540, 8, 1);
    // R9, R8: back-to-back transfers, chip-select never drops
    txn(1, 3'b100, 26'h000_001C, 8, 0);
    txn(0, 3'b011, 26'h000_0104, 2, 0);
    txn(1, 3'b000, 26'h000_0201, 1, 0);
    txn(0, 3'b110, 26'h000_0300, 8, 1);
    // R10: frame early on block, late on single and pair
    txn(1, 3'b100, 26'h001_0008, 3, 1);
    txn(0, 3'b010, 26'h001_0100, 3, 1);
    txn(1, 3'b011, 26'h001_0204, 4, 1);
    // R11: chip-select drop mid-transfer, then stray data-like cycle
    cyc(1, 1, 1, 1, {3'b100, 3'b000, 26'h002_0000});
    cyc(0, 1, 1, 1, 32'h0);
    cyc(0, 1, 1, 1, 32'h0);
    cyc(0, 0, 1, 1, 32'h0);
    cyc(0, 1, 1, 1, 32'h0);
    cyc(0, 1, 0, 1, 32'h0);
    txn(1, 3'b001, 26'h002_0402, 1, 1);
    cyc(0, 0, 0, 0, '0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule